// File: doc/BRIEF.md
# Constant-Time Dual-Scalar Point Multiplication Sequencer

This block drives external point-addition and point-doubling units to produce Q = k·P + l·R, the joint product that signature verification needs. It does not do field arithmetic. It holds the working points, scans the two scalars together from the top bit down, and chooses which point is fed to the adder on each step. Before the scan it issues one addition to form the sum point S = P + R.

Each of the NBITS iterations issues one doubling of the accumulator. When that doubling has returned, it issues one addition. The addend depends on the scalar bit pair. When both bits are zero, the addition goes to a separate dummy accumulator instead of the real one. An addition therefore happens on every iteration, and the run length does not depend on the scalars.

P comes either from the `p_in` port or from a base point fixed by a parameter. R and both scalars always come from ports. Points are packed as {x, y, z}, with x in the top CW bits. The point at infinity is the all-zero word, so z is 0. The external units are expected to handle that value.

Top module: `ecds_dual_mult_seq`

## Requirements
- R1: After reset, `done`, `add_req` and `dbl_req` are low, and no request is issued until `start` is seen.
- R2: A `start` pulse while idle captures `k_in`, `l_in` and `r_in`. It also captures P, which is the `BASE_PT` parameter when `use_base` is 1 and `p_in` when it is 0.
- R3: The first request of a run is an addition with `add_a` = P and `add_b` = R. Its result is kept as the sum point S.
- R4: Each iteration issues a doubling of the accumulator. The addition of that iteration is issued only after the doubling response, and its `add_a` is the doubled accumulator. Operands stay stable while a request is outstanding.
- R5: Bits are taken from index NBITS-1 down to 0. For the pair (k_i, l_i) = 11 the addend `add_b` is S, for 10 it is P, and for 01 it is R.
- R6: For the pair 00, the addition is issued with `add_a` = the dummy accumulator T and `add_b` = S. The result replaces T, and the real accumulator keeps its doubled value.
- R7: Q and T both start each run at the point at infinity (all-zero word, z = 0). The first doubling operand is therefore that value.
- R8: Once all bits are done, `done` pulses for exactly one cycle and `q_out` holds k·P + l·R. No request is outstanding at that point.
- R9: A run issues exactly NBITS doublings and NBITS+1 additions. With fixed unit latencies, the time from `start` to `done` is the same for every scalar pair.
- R10: A `start` pulse during a run is ignored. The run finishes with the operands captured at its own start.
- R11: At most one request is outstanding at any time, and each request is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (one-cycle pulse, honoured when idle) |
| use_base | input | 1 | 1: P is the built-in base point, 0: P is `p_in` |
| k_in | input | NBITS | Scalar applied to P |
| l_in | input | NBITS | Scalar applied to R |
| p_in | input | 3*CW | External point P as {x,y,z} |
| r_in | input | 3*CW | Point R as {x,y,z} |
| done | output | 1 | One-cycle end-of-run pulse |
| q_out | output | 3*CW | Result k·P + l·R as {x,y,z} |
| add_req | output | 1 | Addition command pulse |
| add_a | output | 3*CW | First addition operand |
| add_b | output | 3*CW | Second addition operand |
| add_rsp_valid | input | 1 | Addition result valid |
| add_res | input | 3*CW | Addition result |
| dbl_req | output | 1 | Doubling command pulse |
| dbl_in | output | 3*CW | Doubling operand |
| dbl_rsp_valid | input | 1 | Doubling result valid |
| dbl_res | input | 3*CW | Doubling result |

## Verification
The external units are modelled as a toy modular additive group on the x coordinate. In that group, addition is a sum mod 65521 and doubling is twice the value mod 65521, so the final x must equal k·P + l·R mod 65521.

The bench runs the following scalar pairs:
- Random pairs that mix all four bit pairs. These check the addend choice on each step.
- Both scalars all zero. Here every addition is a dummy and the result must be the point at infinity.
- Both scalars all ones. Here every addition uses S.
- A scalar pair with one of the two scalars zero. This shows whether P and R are swapped.

Runs with the built-in base point tell the two sources of P apart. A second `start` pulse during a run shows whether operands are recaptured. Cycle counts that match across all these patterns show that the timing does not depend on the scalars.

// File: rtl/ecds_pkg.sv
// Shared types for the dual-scalar multiplication sequencer.
package ecds_pkg;

    // Sequencer phases: precompute, then per-bit double and add.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PRE_GO   = 3'd1,
        ST_PRE_WAIT = 3'd2,
        ST_DBL_GO   = 3'd3,
        ST_DBL_WAIT = 3'd4,
        ST_ADD_GO   = 3'd5,
        ST_ADD_WAIT = 3'd6,
        ST_FIN      = 3'd7
    } seq_state_t;

    // Scalar bit pair {k_i, l_i}.
    typedef enum logic [1:0] {
        PAIR_NONE = 2'b00,
        PAIR_L    = 2'b01,
        PAIR_K    = 2'b10,
        PAIR_BOTH = 2'b11
    } bit_pair_t;

endpackage

// File: rtl/ecds_bit_index.sv
// Down-counting scalar bit index.
// It loads NBITS-1 and steps towards 0, and it flags the last bit.
// It assumes that step is never raised at index 0.
module ecds_bit_index #(
    parameter int unsigned NBITS = 16,
    localparam int unsigned IW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] TOP_IDX = IW'(NBITS - 1);

    // Index register: load the top bit, or move one bit down.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx <= '0;
        else if (load)  idx <= TOP_IDX;
        else if (step)  idx <= idx - 1'b1;
    end

    // Last-bit flag for the loop exit.
    always_comb last = (idx == '0);
endmodule

// File: rtl/ecds_unit_port.sv
// Command-side tracker for one external point unit.
// It turns an issue strobe into a one-cycle request pulse.
// It keeps a pending flag until the response arrives.
// It assumes the unit returns exactly one response per request.
module ecds_unit_port (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic rsp_valid,
    output logic req,
    output logic pend
);
    // Request pulse: registered copy of the issue strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= issue;
    end

    // Outstanding flag: set on issue, cleared by the response.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (issue)     pend <= 1'b1;
        else if (rsp_valid) pend <= 1'b0;
    end
endmodule

// File: rtl/ecds_addend_mux.sv
// Operand selection for the per-bit addition.
// The scalar bit pair picks the addend among S, P and R.
// On a 00 pair it routes the dummy accumulator and S instead of the real accumulator.
// Purely combinational.
module ecds_addend_mux
    import ecds_pkg::*;
#(
    parameter int unsigned CW = 16,
    localparam int unsigned PW = 3 * CW
) (
    input  bit_pair_t     pair,
    input  logic [PW-1:0] acc_pt,
    input  logic [PW-1:0] dummy_pt,
    input  logic [PW-1:0] sum_pt,
    input  logic [PW-1:0] p_pt,
    input  logic [PW-1:0] r_pt,
    output logic [PW-1:0] op_a,
    output logic [PW-1:0] op_b,
    output logic          is_dummy
);
    // Addend and accumulator choice from the bit pair.
    always_comb begin
        op_a     = acc_pt;
        is_dummy = 1'b0;
        unique case (pair)
            PAIR_BOTH: op_b = sum_pt;
            PAIR_K:    op_b = p_pt;
            PAIR_L:    op_b = r_pt;
            default: begin
                op_b     = sum_pt;
                op_a     = dummy_pt;
                is_dummy = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ecds_dual_mult_seq.sv
// Constant-time dual-scalar multiplication sequencer, Q = k*P + l*R.
// It first forms S = P + R, then scans both scalars from the top bit down.
// Each iteration is one doubling of Q followed by one addition. A 00 pair adds into a dummy T.
// It assumes the external units handle the all-zero point at infinity.
// It assumes each unit answers each request exactly once.
module ecds_dual_mult_seq
    import ecds_pkg::*;
#(
    parameter int unsigned NBITS = 16,
    parameter int unsigned CW    = 16,
    parameter logic [3*CW-1:0] BASE_PT = 48'h1234_0042_0001,
    localparam int unsigned PW   = 3 * CW,
    localparam int unsigned IW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             use_base,
    input  logic [NBITS-1:0] k_in,
    input  logic [NBITS-1:0] l_in,
    input  logic [PW-1:0]    p_in,
    input  logic [PW-1:0]    r_in,
    output logic             done,
    output logic [PW-1:0]    q_out,
    output logic             add_req,
    output logic [PW-1:0]    add_a,
    output logic [PW-1:0]    add_b,
    input  logic             add_rsp_valid,
    input  logic [PW-1:0]    add_res,
    output logic             dbl_req,
    output logic [PW-1:0]    dbl_in,
    input  logic             dbl_rsp_valid,
    input  logic [PW-1:0]    dbl_res
);
    localparam logic [PW-1:0] INF_PT = '0;

    seq_state_t       state;
    logic [NBITS-1:0] k_r, l_r;
    logic [PW-1:0]    p_r, r_r, s_r, q_r, t_r;
    logic [IW-1:0]    idx;
    logic             last;
    logic             add_pend, dbl_pend;
    logic             add_issue, dbl_issue;
    logic             accept, add_back, dbl_back, step;
    bit_pair_t        pair;
    logic [PW-1:0]    sel_a, sel_b;
    logic             sel_dummy;

    // Handshake events derived from the state.
    always_comb begin
        accept    = (state == ST_IDLE) && start;
        add_issue = (state == ST_PRE_GO) || (state == ST_ADD_GO);
        dbl_issue = (state == ST_DBL_GO);
        add_back  = ((state == ST_PRE_WAIT) || (state == ST_ADD_WAIT)) && add_rsp_valid;
        dbl_back  = (state == ST_DBL_WAIT) && dbl_rsp_valid;
        step      = (state == ST_ADD_WAIT) && add_rsp_valid && !last;
        pair      = bit_pair_t'({k_r[idx], l_r[idx]});
    end

    ecds_bit_index #(.NBITS(NBITS)) u_idx (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .step (step),
        .idx  (idx),
        .last (last)
    );

    ecds_unit_port u_add_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (add_issue),
        .rsp_valid(add_rsp_valid),
        .req      (add_req),
        .pend     (add_pend)
    );

    ecds_unit_port u_dbl_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (dbl_issue),
        .rsp_valid(dbl_rsp_valid),
        .req      (dbl_req),
        .pend     (dbl_pend)
    );

    ecds_addend_mux #(.CW(CW)) u_mux (
        .pair    (pair),
        .acc_pt  (q_r),
        .dummy_pt(t_r),
        .sum_pt  (s_r),
        .p_pt    (p_r),
        .r_pt    (r_r),
        .op_a    (sel_a),
        .op_b    (sel_b),
        .is_dummy(sel_dummy)
    );

    // Phase sequencing: precompute, then double/add per bit, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     if (start) state <= ST_PRE_GO;
                ST_PRE_GO:   state <= ST_PRE_WAIT;
                ST_PRE_WAIT: if (add_rsp_valid) state <= ST_DBL_GO;
                ST_DBL_GO:   state <= ST_DBL_WAIT;
                ST_DBL_WAIT: if (dbl_rsp_valid) state <= ST_ADD_GO;
                ST_ADD_GO:   state <= ST_ADD_WAIT;
                ST_ADD_WAIT: if (add_rsp_valid) state <= last ? ST_FIN : ST_DBL_GO;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    // Operand capture at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_r <= '0;
            l_r <= '0;
            p_r <= '0;
            r_r <= '0;
        end else if (accept) begin
            k_r <= k_in;
            l_r <= l_in;
            p_r <= use_base ? BASE_PT : p_in;
            r_r <= r_in;
        end
    end

    // Sum point register, written by the precompute addition.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         s_r <= '0;
        else if (add_back && (state == ST_PRE_WAIT))        s_r <= add_res;
    end

    // Real accumulator: cleared at start, updated by doublings and non-dummy additions.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         q_r <= INF_PT;
        else if (accept)                                    q_r <= INF_PT;
        else if (dbl_back)                                  q_r <= dbl_res;
        else if (add_back && (state == ST_ADD_WAIT) && !sel_dummy) q_r <= add_res;
    end

    // Dummy accumulator: cleared at start, updated only by 00-pair additions.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         t_r <= INF_PT;
        else if (accept)                                    t_r <= INF_PT;
        else if (add_back && (state == ST_ADD_WAIT) && sel_dummy) t_r <= add_res;
    end

    // Outward operands and status.
    always_comb begin
        if ((state == ST_PRE_GO) || (state == ST_PRE_WAIT)) begin
            add_a = p_r;
            add_b = r_r;
        end else begin
            add_a = sel_a;
            add_b = sel_b;
        end
        dbl_in = q_r;
        q_out  = q_r;
        done   = (state == ST_FIN);
    end
endmodule

// File: rtl/ecds_dual_mult_chk.sv
// Protocol checker for the dual-scalar sequencer, attached with bind.
// It observes the command ports and the per-unit pending flags.
module ecds_dual_mult_chk #(
    parameter int unsigned CW = 16,
    localparam int unsigned PW = 3 * CW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          add_req,
    input logic          dbl_req,
    input logic          add_pend,
    input logic          dbl_pend,
    input logic          add_rsp_valid,
    input logic          dbl_rsp_valid,
    input logic [PW-1:0] add_a,
    input logic [PW-1:0] add_b,
    input logic [PW-1:0] dbl_in
);
    AST_ONE_UNIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_pend && dbl_pend)); // R11
    AST_ADD_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        add_req |=> !add_req); // R11
    AST_DBL_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_req |=> !dbl_req); // R11
    AST_ADD_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (add_pend && !add_rsp_valid) |=> ($stable(add_a) && $stable(add_b))); // R4
    AST_DBL_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_pend && !dbl_rsp_valid) |=> $stable(dbl_in)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!add_pend && !dbl_pend)); // R8
endmodule

bind ecds_dual_mult_seq ecds_dual_mult_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done         (done),
    .add_req      (add_req),
    .dbl_req      (dbl_req),
    .add_pend     (add_pend),
    .dbl_pend     (dbl_pend),
    .add_rsp_valid(add_rsp_valid),
    .dbl_rsp_valid(dbl_rsp_valid),
    .add_a        (add_a),
    .add_b        (add_b),
    .dbl_in       (dbl_in)
);

// File: tb/sim_ecds_dual_mult_seq.sv
// Directed bench. The external units form a toy group on x: addition and doubling mod 65521.
module sim_ecds_dual_mult_seq;
    localparam int NB = 16;
    localparam int CW = 16;
    localparam int PW = 3 * CW;
    localparam longint MODV = 65521;
    localparam int LAT_ADD = 3;
    localparam int LAT_DBL = 2;
    localparam longint BASE_X = 64'h1234;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic use_base = 1'b0;
    logic [NB-1:0] k_in = '0, l_in = '0;
    logic [PW-1:0] p_in = '0, r_in = '0;
    logic done;
    logic [PW-1:0] q_out;
    logic add_req, dbl_req;
    logic [PW-1:0] add_a, add_b, dbl_in;
    logic add_rsp_valid = 1'b0, dbl_rsp_valid = 1'b0;
    logic [PW-1:0] add_res = '0, dbl_res = '0;

    int checks = 0;
    int errors = 0;
    int add_cnt, dbl_cnt, first_dbl_z, ref_cycles;
    longint log_a [0:NB];
    longint log_b [0:NB];

    always #5 clk = ~clk;

    ecds_dual_mult_seq #(.NBITS(NB), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .use_base(use_base),
        .k_in(k_in), .l_in(l_in), .p_in(p_in), .r_in(r_in),
        .done(done), .q_out(q_out),
        .add_req(add_req), .add_a(add_a), .add_b(add_b),
        .add_rsp_valid(add_rsp_valid), .add_res(add_res),
        .dbl_req(dbl_req), .dbl_in(dbl_in),
        .dbl_rsp_valid(dbl_rsp_valid), .dbl_res(dbl_res)
    );

    function automatic longint xof(input logic [PW-1:0] pt);
        return longint'(pt[PW-1 -: CW]);
    endfunction

    function automatic logic [PW-1:0] mkpt(input longint x);
        return {CW'(x), CW'(0), CW'(1)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Addition unit model with operand logging.
    initial forever begin
        @(posedge clk); #1;
        if (add_req) begin
            longint a, b;
            a = xof(add_a); b = xof(add_b);
            if (add_cnt <= NB) begin log_a[add_cnt] = a; log_b[add_cnt] = b; end
            add_cnt++;
            repeat (LAT_ADD - 1) @(posedge clk);
            #1; add_res = mkpt((a + b) % MODV); add_rsp_valid = 1'b1;
            @(posedge clk); #1; add_rsp_valid = 1'b0;
        end
    end

    // Doubling unit model.
    initial forever begin
        @(posedge clk); #1;
        if (dbl_req) begin
            longint a;
            a = xof(dbl_in);
            if (dbl_cnt == 0) first_dbl_z = int'(dbl_in[CW-1:0]) + int'(dbl_in[PW-1:CW] != '0);
            dbl_cnt++;
            repeat (LAT_DBL - 1) @(posedge clk);
            #1; dbl_res = mkpt((2 * a) % MODV); dbl_rsp_valid = 1'b1;
            @(posedge clk); #1; dbl_rsp_valid = 1'b0;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // One full run with independent model of the joint scan and its operand order.
    task automatic run_case(input string name, input logic [NB-1:0] k, input logic [NB-1:0] l,
                            input bit base, input longint px, input longint rx, input bit restart);
        longint pe, s, qe, te, expa [0:NB], expb [0:NB];
        int cyc, bad_pre, bad_sel, bad_dummy;
        pe = base ? BASE_X : px;
        s = (pe + rx) % MODV;
        qe = 0; te = 0;
        expa[0] = pe; expb[0] = rx;
        for (int i = NB - 1; i >= 0; i--) begin
            int j;
            j = NB - i;
            qe = (2 * qe) % MODV;
            case ({k[i], l[i]})
                2'b11: begin expa[j] = qe; expb[j] = s;  qe = (qe + s) % MODV; end
                2'b10: begin expa[j] = qe; expb[j] = pe; qe = (qe + pe) % MODV; end
                2'b01: begin expa[j] = qe; expb[j] = rx; qe = (qe + rx) % MODV; end
                default: begin expa[j] = te; expb[j] = s; te = (te + s) % MODV; end
            endcase
        end
        add_cnt = 0; dbl_cnt = 0; first_dbl_z = -1;
        @(posedge clk); #1;
        k_in = k; l_in = l; use_base = base; p_in = mkpt(px); r_in = mkpt(rx); start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            @(posedge clk); #1; cyc++;
            if (restart && cyc == 30) begin
                // R10: a second start mid-run with different operands must be ignored
                k_in = ~k; l_in = ~l; use_base = ~base; p_in = mkpt(17); r_in = mkpt(99); start = 1'b1;
                @(posedge clk); #1; start = 1'b0; cyc++;
            end
        end
        check(done == 1'b1, "R8", {name, " done seen"}, done, 1);
        check(xof(q_out) == qe, "R8", {name, " result x"}, xof(q_out), qe);
        check(add_cnt == NB + 1, "R9", {name, " addition count"}, add_cnt, NB + 1);
        check(dbl_cnt == NB, "R9", {name, " doubling count"}, dbl_cnt, NB);
        check(first_dbl_z == 0, "R7", {name, " first doubling operand is infinity"}, first_dbl_z, 0);
        bad_pre = (log_a[0] != expa[0] || log_b[0] != expb[0]) ? 1 : 0;
        check(bad_pre == 0, "R3", {name, " precompute operand x of P"}, log_a[0], expa[0]);
        bad_sel = 0; bad_dummy = 0;
        for (int j = 1; j <= NB; j++) begin
            bit dm;
            dm = ({k[NB - j], l[NB - j]} == 2'b00);
            if (log_a[j] != expa[j] || log_b[j] != expb[j]) begin
                if (dm) bad_dummy++; else bad_sel++;
            end
        end
        check(bad_sel == 0, "R5", {name, " addend selection mismatches"}, bad_sel, 0);
        check(bad_dummy == 0, "R6", {name, " dummy addition mismatches"}, bad_dummy, 0);
        if (ref_cycles < 0) ref_cycles = cyc;
        check(cyc == ref_cycles, "R9", {name, " start-to-done cycles"}, cyc, ref_cycles);
        @(posedge clk); #1;
        check(done == 1'b0, "R8", {name, " done is a single pulse"}, done, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(add_req == 1'b0 && dbl_req == 1'b0, "R1", "requests after reset", add_req | dbl_req, 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(add_cnt == 0 && dbl_cnt == 0, "R1", "no request before start", add_cnt + dbl_cnt, 0);
    endtask

    initial begin
        ref_cycles = -1; add_cnt = 0; dbl_cnt = 0;
        test_reset();
        run_case("random_a",   16'hA5C3, 16'h3C96, 1'b0, 1234, 5678, 1'b0);
        run_case("random_b",   16'h0F1E, 16'hF0E1, 1'b0, 40001, 777, 1'b0);
        run_case("all_zero",   16'h0000, 16'h0000, 1'b0, 321, 654, 1'b0);
        run_case("all_one",    16'hFFFF, 16'hFFFF, 1'b0, 9999, 31337, 1'b0);
        run_case("k_only",     16'h8001, 16'h0000, 1'b0, 111, 222, 1'b0);
        run_case("l_only",     16'h0000, 16'h8001, 1'b0, 111, 222, 1'b0);
        // R2: P taken from the built-in base point, p_in ignored
        run_case("base_point", 16'h1357, 16'h2468, 1'b1, 55, 4242, 1'b0);
        // R2: P taken from p_in
        run_case("ext_point",  16'h1357, 16'h2468, 1'b0, 55, 4242, 1'b0);
        run_case("restart",    16'hC0DE, 16'h0BAD, 1'b0, 808, 909, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule